// File: doc/BRIEF.md
# Two-Level Sectioned Page Walker

This block turns a 23-bit virtual address into a 13-bit physical page number when a translation misses. The address is split, from the top bit down, into a 5-bit section number, a 9-bit page number and a 9-bit word offset. Each context (user or executive) has a process table page, located by its own base register. The first 32 words of that page form the section table. A section pointer leads to a 512-word page map. The page-map word for the virtual page then leads to the final physical page. Pointers at both levels share one format and one decoder. An immediate pointer names the next page directly. A shared pointer goes through the special page table (SPT). An indirect pointer names another table through the SPT and the walker decodes again at the index the pointer carries. Because of this, the number of memory reads per walk varies.

When the walk succeeds, the walker can update the core status table (CST). It does a read-modify-write of the entry for the page-map page, then of the entry for the final page, and sets the used bit in each. It then writes the result into a 512-entry direct-mapped translation buffer and pulses a done response. A separate combinational lookup port reads that buffer.

Top module: `sect_page_walker`

## Requirements
- R1: After reset, `req_ready_o` is high, `done_o` and `mem_req_o` are low, and every lookup misses.
- R2: A walk first reads the word at physical address {ctx_base, 4'b0000, section}. `ctx_base` is `upt_base_i` when `req_user_i` is 1 and `ept_base_i` when it is 0. The same virtual address in the two contexts therefore resolves through separate tables.
- R3: A pointer word's kind is in bits [35:33]: 1 is immediate, with the page in [12:0]; 2 is shared, with the SPT index in [17:0]; 3 is indirect, with the table index in [26:18] and the SPT index in [17:0]. Codes 0 and 4 to 7 are invalid. An SPT entry sits at `spt_base_i` + index and holds a page number in [12:0].
- R4: Once the page-map page P is known, the walker reads word {P, virtual page}, decodes it, and the page it resolves to is the result.
- R5: A shared pointer, at either level, resolves to the page held in the SPT entry it indexes.
- R6: An indirect pointer reads the SPT entry it indexes. It then reads the table at {that page, table index} and decodes the word found there as a pointer at the same level.
- R7: An invalid section pointer ends the walk with `fault_o`=1 and cause 1. An invalid page-map pointer ends it with cause 2. A faulting walk fills no buffer entry.
- R8: Up to 8 indirect pointers per level are followed. The 9th indirect pointer at one level ends the walk with cause 3.
- R9: With `cst_en_i` high, a successful walk does a read-modify-write that sets bit 0 of the word at `cst_base_i` + page-map page, then one at `cst_base_i` + final page. All other bits are kept. With `cst_en_i` low, the walker issues no memory writes.
- R10: A successful walk pulses `done_o` for one cycle with `fault_o`=0 and the page on `ppn_o`. Afterwards, a lookup with the same context and {section, page} hits and returns that page. The buffer is indexed by the 9-bit virtual page alone, so a later fill at the same index displaces the earlier entry.
- R11: While `mem_req_o` is high and `mem_ack_i` is low, `mem_req_o`, `mem_addr_o` and `mem_we_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Walker idle, request accepted on valid |
| req_user_i | input | 1 | 1 = user context, 0 = executive |
| req_vaddr_i | input | 23 | Virtual address {section, page, offset} |
| upt_base_i | input | 13 | User process table page |
| ept_base_i | input | 13 | Executive process table page |
| spt_base_i | input | 22 | SPT physical word address |
| cst_base_i | input | 22 | CST physical word address |
| cst_en_i | input | 1 | Enable status table updates |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 22 | Physical word address |
| mem_wdata_o | output | 36 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 36 | Read data |
| done_o | output | 1 | One-cycle walk completion |
| fault_o | output | 1 | Walk ended in a fault |
| fault_cause_o | output | 2 | 0 none, 1 section, 2 page, 3 hop limit |
| ppn_o | output | 13 | Resolved physical page |
| lkp_user_i | input | 1 | Lookup context |
| lkp_vpn_i | input | 14 | Lookup {section, page} |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_ppn_o | output | 13 | Lookup physical page |

## Verification
The assertions assume memory follows a plain request/acknowledge protocol: it acknowledges only while a request is pending, and it returns read data in the acknowledge cycle. They also assume `cst_en_i` and the base registers stay constant during a walk. The bench memory model acknowledges after a rotating delay of one to three cycles, and acknowledges only requests that are still pending. Base registers and the enable are changed only while the walker is idle. The table contents are chosen so that every indirect chain ends within a known number of hops, except the one chain built on purpose to exceed the limit.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int unsigned WORD_W    = 36;
  localparam int unsigned PPN_W     = 13;
  localparam int unsigned OFS_W     = 9;
  localparam int unsigned SEC_W     = 5;
  localparam int unsigned VA_W      = SEC_W + 2 * OFS_W;
  localparam int unsigned PA_W      = PPN_W + OFS_W;
  localparam int unsigned SPT_IDX_W = 18;
  localparam int unsigned KIND_W    = 3;
  localparam int unsigned TIDX_LSB  = SPT_IDX_W;

  typedef enum logic [1:0] {PT_INVALID, PT_IMMED, PT_SHARED, PT_INDIR} ptr_kind_e;
  typedef enum logic [1:0] {FC_NONE, FC_SECT, FC_PAGE, FC_HOPS} fault_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PTR, ST_SPT, ST_CST_RD, ST_CST_WR, ST_DONE} walk_st_e;

  typedef struct packed {
    ptr_kind_e              kind;
    logic [OFS_W-1:0]       tidx;
    logic [SPT_IDX_W-1:0]   spt_idx;
    logic [PPN_W-1:0]       page;
  } ptr_t;
endpackage

// File: rtl/spw_ptr_dec.sv
module spw_ptr_dec
  import spw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output ptr_t              ptr_o
);
  logic [KIND_W-1:0] code;
  logic              unused_mid;

  assign code       = word_i[WORD_W-1 -: KIND_W];
  assign unused_mid = ^word_i[WORD_W-KIND_W-1 : TIDX_LSB+OFS_W];

  always_comb begin
    ptr_o.kind    = (code > KIND_W'(3)) ? PT_INVALID : ptr_kind_e'(code[1:0]);
    ptr_o.tidx    = word_i[TIDX_LSB +: OFS_W];
    ptr_o.spt_idx = word_i[SPT_IDX_W-1:0];
    ptr_o.page    = word_i[PPN_W-1:0];
  end
endmodule

// File: rtl/spw_tlb.sv
module spw_tlb #(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [IDX_W-1:0]  lkp_idx_i,
  input  logic [TAG_W-1:0]  lkp_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q <= '0;
    else if (fill_i) vld_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx_i] <= fill_tag_i;
      dat_q[fill_idx_i] <= fill_data_i;
    end
  end

  assign hit_o  = vld_q[lkp_idx_i] && (tag_q[lkp_idx_i] == lkp_tag_i);
  assign data_o = dat_q[lkp_idx_i];
endmodule

// File: rtl/spw_walk.sv
module spw_walk
  import spw_pkg::*;
#(
  parameter int unsigned MAX_HOPS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_user_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [PPN_W-1:0]  upt_base_i,
  input  logic [PPN_W-1:0]  ept_base_i,
  input  logic [PA_W-1:0]   spt_base_i,
  input  logic [PA_W-1:0]   cst_base_i,
  input  logic              cst_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  ptr_t              ptr_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        cause_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              fill_o,
  output logic [OFS_W-1:0]  fill_idx_o,
  output logic [SEC_W:0]    fill_tag_o
);
  localparam int unsigned HOP_W = $clog2(MAX_HOPS + 1);

  walk_st_e            st_q;
  logic                lvl_q, user_q, ind_q, cst_sel_q;
  logic [HOP_W-1:0]    hops_q;
  logic [SEC_W-1:0]    sec_q;
  logic [OFS_W-1:0]    pg_q, tidx_q;
  logic [PA_W-1:0]     addr_q;
  logic [PPN_W-1:0]    pmap_q, final_q;
  logic [WORD_W-1:0]   cst_data_q;
  fault_e              cause_q;
  logic                res_v;
  logic [SEC_W-1:0]    req_sec;
  logic [PPN_W-1:0]    ctx_base;

  assign req_sec  = req_vaddr_i[VA_W-1 -: SEC_W];
  assign ctx_base = req_user_i ? upt_base_i : ept_base_i;

  // next-level page known: immediate pointer, or SPT entry of a shared pointer
  assign res_v = mem_ack_i &&
                 (((st_q == ST_PTR) && (ptr_i.kind == PT_IMMED)) ||
                  ((st_q == ST_SPT) && !ind_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; lvl_q <= 1'b0; user_q <= 1'b0; ind_q <= 1'b0;
      cst_sel_q <= 1'b0; hops_q <= '0; sec_q <= '0; pg_q <= '0; tidx_q <= '0;
      addr_q <= '0; pmap_q <= '0; final_q <= '0; cst_data_q <= '0;
      cause_q <= FC_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          user_q  <= req_user_i;
          sec_q   <= req_sec;
          pg_q    <= req_vaddr_i[OFS_W +: OFS_W];
          addr_q  <= {ctx_base, {(OFS_W-SEC_W){1'b0}}, req_sec};
          lvl_q   <= 1'b0;
          hops_q  <= '0;
          cause_q <= FC_NONE;
          st_q    <= ST_PTR;
        end
        ST_PTR: if (mem_ack_i) begin
          if (ptr_i.kind == PT_INVALID) begin
            cause_q <= lvl_q ? FC_PAGE : FC_SECT;
            st_q    <= ST_DONE;
          end else if (ptr_i.kind == PT_INDIR && hops_q == HOP_W'(MAX_HOPS)) begin
            cause_q <= FC_HOPS;
            st_q    <= ST_DONE;
          end else if (ptr_i.kind != PT_IMMED) begin
            addr_q <= spt_base_i + PA_W'(ptr_i.spt_idx);
            ind_q  <= (ptr_i.kind == PT_INDIR);
            tidx_q <= ptr_i.tidx;
            if (ptr_i.kind == PT_INDIR) hops_q <= hops_q + 1'b1;
            st_q   <= ST_SPT;
          end
        end
        ST_SPT: if (mem_ack_i && ind_q) begin
          addr_q <= {ptr_i.page, tidx_q};
          st_q   <= ST_PTR;
        end
        ST_CST_RD: if (mem_ack_i) begin
          cst_data_q <= mem_rdata_i;
          st_q       <= ST_CST_WR;
        end
        ST_CST_WR: if (mem_ack_i) begin
          if (!cst_sel_q) begin
            cst_sel_q <= 1'b1;
            addr_q    <= cst_base_i + PA_W'(final_q);
            st_q      <= ST_CST_RD;
          end else begin
            st_q <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase

      if (res_v) begin
        if (!lvl_q) begin
          pmap_q <= ptr_i.page;
          lvl_q  <= 1'b1;
          hops_q <= '0;
          addr_q <= {ptr_i.page, pg_q};
          st_q   <= ST_PTR;
        end else begin
          final_q <= ptr_i.page;
          if (cst_en_i) begin
            cst_sel_q <= 1'b0;
            addr_q    <= cst_base_i + PA_W'(pmap_q);
            st_q      <= ST_CST_RD;
          end else begin
            st_q <= ST_DONE;
          end
        end
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_PTR) || (st_q == ST_SPT) ||
                       (st_q == ST_CST_RD) || (st_q == ST_CST_WR);
  assign mem_we_o    = (st_q == ST_CST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = cst_data_q | WORD_W'(1);
  assign done_o      = (st_q == ST_DONE);
  assign fault_o     = (cause_q != FC_NONE);
  assign cause_o     = cause_q;
  assign ppn_o       = final_q;
  assign fill_o      = done_o && (cause_q == FC_NONE);
  assign fill_idx_o  = pg_q;
  assign fill_tag_o  = {user_q, sec_q};

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o);
  a_r8_hop_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hops_q <= HOP_W'(MAX_HOPS));
  a_r9_cst_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> cst_en_i);
endmodule

// File: rtl/sect_page_walker.sv
module sect_page_walker
  import spw_pkg::*;
#(
  parameter int unsigned MAX_HOPS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_user_i,
  input  logic [VA_W-1:0]      req_vaddr_i,
  input  logic [PPN_W-1:0]     upt_base_i,
  input  logic [PPN_W-1:0]     ept_base_i,
  input  logic [PA_W-1:0]      spt_base_i,
  input  logic [PA_W-1:0]      cst_base_i,
  input  logic                 cst_en_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [PA_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [1:0]           fault_cause_o,
  output logic [PPN_W-1:0]     ppn_o,
  input  logic                 lkp_user_i,
  input  logic [SEC_W+OFS_W-1:0] lkp_vpn_i,
  output logic                 lkp_hit_o,
  output logic [PPN_W-1:0]     lkp_ppn_o
);
  localparam int unsigned TAG_W = SEC_W + 1;

  ptr_t             ptr;
  logic             fill;
  logic [OFS_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;

  spw_ptr_dec u_dec (
    .word_i (mem_rdata_i),
    .ptr_o  (ptr)
  );

  spw_walk #(.MAX_HOPS(MAX_HOPS)) u_walk (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_user_i, .req_vaddr_i,
    .upt_base_i, .ept_base_i, .spt_base_i, .cst_base_i, .cst_en_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .ptr_i      (ptr),
    .done_o, .fault_o,
    .cause_o    (fault_cause_o),
    .ppn_o,
    .fill_o     (fill),
    .fill_idx_o (fill_idx),
    .fill_tag_o (fill_tag)
  );

  spw_tlb #(.IDX_W(OFS_W), .TAG_W(TAG_W), .DATA_W(PPN_W)) u_tlb (
    .clk_i, .rst_ni,
    .fill_i      (fill),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .fill_data_i (ppn_o),
    .lkp_idx_i   (lkp_vpn_i[OFS_W-1:0]),
    .lkp_tag_i   ({lkp_user_i, lkp_vpn_i[OFS_W +: SEC_W]}),
    .hit_o       (lkp_hit_o),
    .data_o      (lkp_ppn_o)
  );
endmodule

// File: tb/sect_page_walker_bench.sv
module sect_page_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] UPT = 13'h0020, EPT = 13'h0010;
  localparam logic [21:0] SPT = 22'h300000, CST = 22'h380000;

  // {user, sec, page, cst_en, cause, ppn}
  localparam logic [30:0] VEC [9] = '{
    {1'b1, 5'd0, 9'd5, 1'b1, 2'd0, 13'h0ABC},  // R4 immediate at both levels
    {1'b1, 5'd0, 9'd6, 1'b1, 2'd0, 13'h0DEF},  // R5 shared page pointer
    {1'b1, 5'd0, 9'd7, 1'b1, 2'd0, 13'h1234},  // R6 indirect page pointer
    {1'b1, 5'd0, 9'd8, 1'b1, 2'd2, 13'h0000},  // R7 invalid page pointer
    {1'b1, 5'd1, 9'd0, 1'b1, 2'd1, 13'h0000},  // R7 invalid section pointer
    {1'b1, 5'd2, 9'd5, 1'b1, 2'd0, 13'h0777},  // R5 shared section pointer
    {1'b1, 5'd3, 9'd5, 1'b1, 2'd0, 13'h0042},  // R8 exactly 8 indirect hops
    {1'b1, 5'd4, 9'd5, 1'b1, 2'd3, 13'h0000},  // R8 9th hop faults
    {1'b0, 5'd0, 9'd5, 1'b0, 2'd0, 13'h1555}   // R2 executive context, R9 cst off
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_user = 1'b0;
  logic [22:0] req_vaddr = '0;
  logic cst_en = 1'b1;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [21:0] mem_addr;
  logic [35:0] mem_wdata, mem_rdata = '0;
  logic done, fault;
  logic [1:0] cause;
  logic [12:0] ppn, lkp_ppn;
  logic lkp_user = 1'b0, lkp_hit;
  logic [13:0] lkp_vpn = '0;

  logic [35:0] mem [logic [21:0]];
  logic [21:0] wlog [16];
  int nwr = 0, hold_err = 0, dly = 0, lat = 0;
  bit pend = 1'b0;
  logic [21:0] held_a = '0;
  logic held_we = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sect_page_walker u_sect_page_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_user_i(req_user), .req_vaddr_i(req_vaddr), .upt_base_i(UPT), .ept_base_i(EPT),
    .spt_base_i(SPT), .cst_base_i(CST), .cst_en_i(cst_en),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_cause_o(cause), .ppn_o(ppn),
    .lkp_user_i(lkp_user), .lkp_vpn_i(lkp_vpn), .lkp_hit_o(lkp_hit), .lkp_ppn_o(lkp_ppn)
  );

  function automatic logic [35:0] rd(input logic [21:0] a);
    return mem.exists(a) ? mem[a] : 36'd0;
  endfunction
  function automatic logic [35:0] p_imm(input logic [12:0] pg);
    return {3'd1, 20'd0, pg};
  endfunction
  function automatic logic [35:0] p_sh(input logic [17:0] idx);
    return {3'd2, 15'd0, idx};
  endfunction
  function automatic logic [35:0] p_ind(input logic [8:0] t, input logic [17:0] idx);
    return {3'd3, 6'd0, t, idx};
  endfunction

  // memory model: rotating 1..3 cycle acknowledge latency
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      if (pend && (mem_addr != held_a || mem_we != held_we)) hold_err++;
      pend <= 1'b1; held_a <= mem_addr; held_we <= mem_we;
      if (dly >= lat) begin
        mem_ack <= 1'b1; dly <= 0; lat <= (lat + 1) % 3; pend <= 1'b0;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wlog[nwr % 16] = mem_addr;
          nwr++;
        end else begin
          mem_rdata <= rd(mem_addr);
        end
      end else begin
        dly <= dly + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic u, input logic [4:0] s, input logic [8:0] p);
    lkp_user = u; lkp_vpn = {s, p};
    #1;
  endtask

  task automatic run_walk(input logic u, input logic [4:0] s, input logic [8:0] p,
                          output logic f, output logic [1:0] c, output logic [12:0] r);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_user = u; req_vaddr = {s, p, 9'h1A5};
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "walk watchdog", t, 0);
    f = fault; c = cause; r = ppn;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL global watchdog actual=expired expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic f;
    logic [1:0] c;
    logic [12:0] r;
    int w0;
    // tables
    mem[{UPT, 9'd0}] = p_imm(13'h100);
    mem[{13'h100, 9'd5}] = p_imm(13'hABC);
    mem[{13'h100, 9'd6}] = p_sh(18'd7);
    mem[SPT + 22'd7] = 36'h0DEF;
    mem[{13'h100, 9'd7}] = p_ind(9'd9, 18'd8);
    mem[SPT + 22'd8] = 36'h0200;
    mem[{13'h200, 9'd9}] = p_imm(13'h1234);
    mem[{UPT, 9'd2}] = p_sh(18'd3);
    mem[SPT + 22'd3] = 36'h0300;
    mem[{13'h300, 9'd5}] = p_imm(13'h0777);
    mem[{UPT, 9'd3}] = p_ind(9'd10, 18'd20);
    for (int k = 0; k < 8; k++) begin
      mem[SPT + 22'(20 + k)] = 36'(13'h500 + 13'(k));
      mem[{13'h500 + 13'(k), 9'd10}] = (k < 7) ? p_ind(9'd10, 18'(21 + k)) : p_imm(13'h600);
    end
    mem[{13'h600, 9'd5}] = p_imm(13'h0042);
    mem[{UPT, 9'd4}] = p_ind(9'd11, 18'd30);
    for (int k = 0; k < 8; k++) begin
      mem[SPT + 22'(30 + k)] = 36'(13'h700 + 13'(k));
      mem[{13'h700 + 13'(k), 9'd11}] = p_ind(9'd11, 18'(31 + k));
    end
    mem[{EPT, 9'd0}] = p_imm(13'h400);
    mem[{13'h400, 9'd5}] = p_imm(13'h1555);
    mem[CST + 22'hABC] = 36'h5_0000_0000;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
    lookup(1'b1, 5'd0, 9'd5);
    chk(lkp_hit === 1'b0, "R1 lookup miss", lkp_hit, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      logic [30:0] v;
      v = VEC[i];
      cst_en = v[15];
      w0 = nwr;
      run_walk(v[30], v[29:25], v[24:16], f, c, r);
      chk(c == v[14:13], "R7/R8 fault cause", c, v[14:13]);
      chk(f == (v[14:13] != 2'd0), "R7 fault flag", f, v[14:13] != 2'd0);
      lookup(v[30], v[29:25], v[24:16]);
      if (v[14:13] == 2'd0) begin
        chk(r == v[12:0], "R10 ppn (R4/R5/R6/R2)", r, v[12:0]);
        chk(lkp_hit && lkp_ppn == v[12:0], "R10 buffer fill", {lkp_hit, lkp_ppn}, {1'b1, v[12:0]});
        chk(nwr - w0 == (v[15] ? 2 : 0), "R9 write count", nwr - w0, v[15] ? 2 : 0);
      end else begin
        chk(lkp_hit === 1'b0, "R7 no fill", lkp_hit, 0);
        chk(nwr == w0, "R7 no writes", nwr - w0, 0);
      end
      if (i == 0) begin
        chk(wlog[w0 % 16] == CST + 22'h100, "R9 first update page map", wlog[w0 % 16], CST + 22'h100);
        chk(wlog[(w0 + 1) % 16] == CST + 22'hABC, "R9 second update final", wlog[(w0 + 1) % 16], CST + 22'hABC);
        chk(rd(CST + 22'hABC) == 36'h5_0000_0001, "R9 used bit kept others", rd(CST + 22'hABC), 36'h5_0000_0001);
        chk(rd(CST + 22'h100) == 36'h1, "R9 page map used bit", rd(CST + 22'h100), 1);
      end
    end

    // R10 direct-mapped replacement, R2 context separation
    lookup(1'b1, 5'd0, 9'd5);
    chk(lkp_hit === 1'b0, "R10 displaced entry misses", lkp_hit, 0);
    lookup(1'b0, 5'd0, 9'd5);
    chk(lkp_hit && lkp_ppn == 13'h1555, "R2 executive entry", lkp_ppn, 13'h1555);
    lookup(1'b1, 5'd0, 9'd6);
    chk(lkp_hit && lkp_ppn == 13'h0DEF, "R10 other index kept", lkp_ppn, 13'h0DEF);
    // R3 unused codes 4..7 are invalid
    cst_en = 1'b1;
    mem[{UPT, 9'd5}] = {3'd5, 20'd0, 13'h100};
    run_walk(1'b1, 5'd5, 9'd5, f, c, r);
    chk(f && c == 2'd1, "R3 reserved kind invalid", c, 1);
    chk(hold_err == 0, "R11 request held until ack", hold_err, 0);
    chk(req_ready === 1'b1 && mem_req === 1'b0, "R1 idle after walks", mem_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule